// File: doc/BRIEF.md
# SRAM access sequencer and decoder

This block is the synchronous front end of a partitioned low-power static memory. It runs on a fast timing clock and divides it into access frames of fixed length. On the last tick of each frame it captures a command: read, write or neither. It also captures a 15-bit word address and 32-bit write data. During the following frame it drives the per-block, per-row and per-column select lines, and it steps precharge, write drive, the word-line pulse and sense enable in a fixed order.

The address splits into a 5-bit block field, an 8-bit row field and a 2-bit word field. The row field is decoded in two levels. A 6-to-64 predecode is held for the whole frame. The top two row bits steer the short word-line pulse into one of four branches. Each final word line is the AND of one branch and one predecode line. A behavioural array stands in for the bitcells, so that data written through the block can be read back through it.

Phase lengths are counted in timing-clock ticks and set by parameters: P precharge, D drive lead, W word-line pulse, S sense, H hold. A frame lasts F = P+D+W+S+H ticks. With the defaults (all 2) F is 10. In the requirements below, tick t is the count of timing-clock edges since the frame began, so t runs from 0 to F-1.

Top module: `sram_seq`

## Requirements
- R1: While rst_ni is low, and in the first frame after it rises, every select and strobe output is zero, err_o is low and rdata_o is zero.
- R2: During a read or write frame, blk_en_o is one-hot at index addr[14:10]. In every other frame it is zero.
- R3: During a read or write frame, row_pre_o is one-hot at index addr[7:2] for the whole frame. wl_grp_o is one-hot at index addr[9:8] only while the word-line pulse is high. At the same time wl_o is one-hot at index addr[9:2]. At all other times wl_grp_o and wl_o are zero.
- R4: During a read or write frame, col_sel_o is one-hot at index addr[1:0]. In other frames it is zero.
- R5: Read frame timing:
  - pre_o is high for t in [0,P).
  - The word line is high for t in [P,P+W).
  - sae_o is high for t in [P+W,P+W+S) and is started by the end of the word-line pulse.
  - wdrv_o stays low.
- R6: Write frame timing:
  - pre_o is high for t in [0,P).
  - wdrv_o is high for t in [P,P+D+W).
  - The word line is high for t in [P+D,P+D+W), so it starts only after the drive lead.
  - sae_o stays low.
- R7: rdata_o takes the value of the addressed word at the edge that ends the sense window, at tick P+W+S of a read frame. It then holds until the next read frame updates it, through precharge and hold.
- R8: A frame with neither rd_i nor wr_i sampled raises no select or strobe output and leaves rdata_o unchanged.
- R9: If rd_i and wr_i are both sampled high, the frame is a no-op. err_o is high for exactly that frame, no output toggles and the stored data does not change.
- R10: A read in the frame directly after a write to the same address returns the newly written data.
- R11: cyc_o is high only on tick F-1. Command inputs are sampled only at the edge that ends that tick. A pulse on rd_i or wr_i that is removed before that edge has no effect.
- R12: The stand-in array holds 2^MEM_AW words, indexed by addr[MEM_AW-1:0] (MEM_AW is 10 by default). Addresses that agree in those bits share one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Read command, sampled at frame end |
| wr_i | input | 1 | Write command, sampled at frame end |
| addr_i | input | 15 | Word address {block, row, word} |
| wdata_i | input | 32 | Write data |
| cyc_o | output | 1 | High on the sampling tick of each frame |
| err_o | output | 1 | Conflicting command flagged for one frame |
| blk_en_o | output | 32 | One-hot block enable |
| row_pre_o | output | 64 | One-hot row predecode |
| wl_grp_o | output | 4 | Gated word-line pulse branches |
| wl_o | output | 256 | Final word lines |
| col_sel_o | output | 4 | One-hot word-in-row select |
| pre_o | output | 1 | Bitline precharge |
| wdrv_o | output | 1 | Write driver enable |
| sae_o | output | 1 | Sense-amp enable |
| rdata_o | output | 32 | Read data register |

## Verification
The hardest case to reach from the ports is a read issued in the frame directly after a write to the same word. It only passes if the array update at the end of the write pulse lands before the sense capture of the next frame. A second hard case is a pair of addresses that differ only in block bits yet map to the same stand-in word.

The stimulus reaches these cases with directed back-to-back frames. The random phase mixes commands at seeded random addresses and turns reads of never-written words into writes, so every read has a known expected value. Stray command pulses between sampling edges, and simultaneous read and write, are also driven in directed frames.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/sram_seq_dec.sv
module sram_seq_dec #(
  parameter int IN_W = 2
) (
  input  logic                    en_i,
  input  logic [IN_W-1:0]         sel_i,
  output logic [(1<<IN_W)-1:0]    oh_o
);
  localparam int N_OUT = 1 << IN_W;
  for (genvar i = 0; i < N_OUT; i++) begin : g_oh
    assign oh_o[i] = en_i && (sel_i == IN_W'(i));
  end
endmodule

// File: rtl/sram_seq_pulse.sv
module sram_seq_pulse #(
  parameter int LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o,
  output logic done_o
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (trig_i)          cnt_q <= CW'(LEN);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign pulse_o = (cnt_q != '0);
  // last high tick; next stage fires on this edge
  assign done_o  = (cnt_q == CW'(1));
endmodule

// File: rtl/sram_seq_array.sv
module sram_seq_array #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int BLK_W  = 5,
  parameter int GRP_W  = 2,
  parameter int PRE_W  = 6,
  parameter int COL_W  = 2,
  parameter int DATA_W = 32,
  parameter int MEM_AW = 10,
  parameter int PRE_T  = 2,
  parameter int DRV_T  = 2,
  parameter int WL_T   = 2,
  parameter int SA_T   = 2,
  parameter int HOLD_T = 2,
  localparam int ROW_W  = GRP_W + PRE_W,
  localparam int ADDR_W = BLK_W + ROW_W + COL_W,
  localparam int N_BLK  = 1 << BLK_W,
  localparam int N_GRP  = 1 << GRP_W,
  localparam int N_PRE  = 1 << PRE_W,
  localparam int N_ROW  = 1 << ROW_W,
  localparam int N_COL  = 1 << COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              cyc_o,
  output logic              err_o,
  output logic [N_BLK-1:0]  blk_en_o,
  output logic [N_PRE-1:0]  row_pre_o,
  output logic [N_GRP-1:0]  wl_grp_o,
  output logic [N_ROW-1:0]  wl_o,
  output logic [N_COL-1:0]  col_sel_o,
  output logic              pre_o,
  output logic              wdrv_o,
  output logic              sae_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int FRAME = PRE_T + DRV_T + WL_T + SA_T + HOLD_T;
  localparam int CNT_W = (FRAME > 2) ? $clog2(FRAME) : 1;
  localparam logic [CNT_W-1:0] LAST_T   = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] PRE_END  = CNT_W'(PRE_T);
  localparam logic [CNT_W-1:0] DRV_END  = CNT_W'(PRE_T + DRV_T + WL_T);
  localparam logic [CNT_W-1:0] RD_TRIG  = CNT_W'(PRE_T - 1);
  localparam logic [CNT_W-1:0] WR_TRIG  = CNT_W'(PRE_T + DRV_T - 1);

  logic [CNT_W-1:0]  cnt_q;
  op_e               op_q;
  logic              err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] mem_rd;
  logic              active, is_rd, is_wr, sample;
  logic              wl_trig, wl_on, wl_done;
  logic              sa_trig, sa_on, sa_done;

  // frame tick counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST_T) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CNT_W'(1);
  end

  assign sample = (cnt_q == LAST_T);
  assign cyc_o  = sample;

  // command capture at frame boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_IDLE;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (sample) begin
      err_q   <= rd_i && wr_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      if (rd_i && !wr_i)      op_q <= OP_RD;
      else if (wr_i && !rd_i) op_q <= OP_WR;
      else                    op_q <= OP_IDLE;
    end
  end

  assign is_rd  = (op_q == OP_RD);
  assign is_wr  = (op_q == OP_WR);
  assign active = is_rd || is_wr;
  assign err_o  = err_q;

  assign pre_o  = active && (cnt_q < PRE_END);
  assign wdrv_o = is_wr && (cnt_q >= PRE_END) && (cnt_q < DRV_END);

  // write holds the pulse back by the drive lead
  assign wl_trig = (is_rd && cnt_q == RD_TRIG) || (is_wr && cnt_q == WR_TRIG);

  sram_seq_pulse #(.LEN(WL_T)) u_wl_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (wl_trig),
    .pulse_o (wl_on),
    .done_o  (wl_done)
  );

  // sense timer is fired by the end of the word-line pulse
  assign sa_trig = wl_done && is_rd;

  sram_seq_pulse #(.LEN(SA_T)) u_sa_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (sa_trig),
    .pulse_o (sa_on),
    .done_o  (sa_done)
  );

  assign sae_o = sa_on;

  // address decode
  logic [BLK_W-1:0] blk_f;
  logic [GRP_W-1:0] grp_f;
  logic [PRE_W-1:0] pre_f;
  logic [COL_W-1:0] col_f;

  assign col_f = addr_q[COL_W-1:0];
  assign pre_f = addr_q[COL_W +: PRE_W];
  assign grp_f = addr_q[COL_W+PRE_W +: GRP_W];
  assign blk_f = addr_q[COL_W+ROW_W +: BLK_W];

  sram_seq_dec #(.IN_W(BLK_W)) u_blk_dec (
    .en_i (active), .sel_i (blk_f), .oh_o (blk_en_o)
  );
  sram_seq_dec #(.IN_W(PRE_W)) u_pre_dec (
    .en_i (active), .sel_i (pre_f), .oh_o (row_pre_o)
  );
  sram_seq_dec #(.IN_W(GRP_W)) u_grp_dec (
    .en_i (wl_on),  .sel_i (grp_f), .oh_o (wl_grp_o)
  );
  sram_seq_dec #(.IN_W(COL_W)) u_col_dec (
    .en_i (active), .sel_i (col_f), .oh_o (col_sel_o)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    for (genvar p = 0; p < N_PRE; p++) begin : g_row
      assign wl_o[g*N_PRE + p] = wl_grp_o[g] & row_pre_o[p];
    end
  end

  // stand-in bitcell array
  sram_seq_array #(.AW(MEM_AW), .DW(DATA_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (wl_done && is_wr),
    .addr_i  (addr_q[MEM_AW-1:0]),
    .wdata_i (wdata_q),
    .rdata_o (mem_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (sa_done) rdata_q <= mem_rd;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int N_BLK  = 32,
  parameter int N_ROW  = 256,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              err_o,
  input logic [N_BLK-1:0]  blk_en_o,
  input logic [N_ROW-1:0]  wl_o,
  input logic              pre_o,
  input logic              wdrv_o,
  input logic              sae_o,
  input logic [DATA_W-1:0] rdata_o
);
  AST_BLK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(blk_en_o)); // R2

  AST_WL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wl_o)); // R3

  AST_PRE_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_o |-> (wl_o == '0) && !sae_o && !wdrv_o); // R5

  AST_SAE_NO_WL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sae_o |-> (wl_o == '0)); // R5

  AST_NO_SAE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdrv_o |-> !sae_o); // R6

  AST_WL_AFTER_DRV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(|wl_o) && wdrv_o) |-> $past(wdrv_o)); // R6

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> ($past(sae_o) && !sae_o)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_en_o == '0) |-> ((wl_o == '0) && !sae_o && !wdrv_o && !pre_o)); // R8

  AST_ERR_NOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (blk_en_o == '0)); // R9
endmodule

bind sram_seq sram_seq_chk #(
  .N_BLK  (N_BLK),
  .N_ROW  (N_ROW),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .err_o    (err_o),
  .blk_en_o (blk_en_o),
  .wl_o     (wl_o),
  .pre_o    (pre_o),
  .wdrv_o   (wdrv_o),
  .sae_o    (sae_o),
  .rdata_o  (rdata_o)
);

// File: tb/sram_seq_bench.sv
module sram_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P = 2, D = 2, W = 2, S = 2, H = 2;
  localparam int F = P + D + W + S + H;
  localparam int AW = 15, DW = 32, MAW = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rd_i = 1'b0, wr_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          cyc_o, err_o, pre_o, wdrv_o, sae_o;
  logic [31:0]   blk_en_o;
  logic [63:0]   row_pre_o;
  logic [3:0]    wl_grp_o, col_sel_o;
  logic [255:0]  wl_o;
  logic [DW-1:0] rdata_o;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] mdl [1<<MAW];
  bit            vld [1<<MAW];
  logic [DW-1:0] last_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_seq #(.PRE_T(P), .DRV_T(D), .WL_T(W), .SA_T(S), .HOLD_T(H),
             .MEM_AW(MAW)) u_sram_seq (
    .clk_i(clk), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .cyc_o(cyc_o), .err_o(err_o),
    .blk_en_o(blk_en_o), .row_pre_o(row_pre_o), .wl_grp_o(wl_grp_o),
    .wl_o(wl_o), .col_sel_o(col_sel_o), .pre_o(pre_o), .wdrv_o(wdrv_o),
    .sae_o(sae_o), .rdata_o(rdata_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_ctl(input int op, input int t);
    logic pre, wl, sae, drv;
    pre = (op != 0) && t < P;
    wl  = (op == 1) ? (t >= P && t < P+W) :
          (op == 2) ? (t >= P+D && t < P+D+W) : 1'b0;
    sae = (op == 1) && t >= P+W && t < P+W+S;
    drv = (op == 2) && t >= P && t < P+D+W;
    return {pre, wl, sae, drv};
  endfunction

  // one access frame: op 0 idle, 1 read, 2 write
  task automatic run_frame(input logic rd, input logic wr,
                           input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input string tag);
    int op, idx;
    logic [DW-1:0] nrd;
    logic [3:0] c;
    while (!cyc_o) @(negedge clk);
    rd_i = rd; wr_i = wr; addr_i = a; wdata_i = d;
    op  = (rd && !wr) ? 1 : (wr && !rd) ? 2 : 0;
    idx = int'(a[MAW-1:0]);
    nrd = (op == 1) ? mdl[idx] : last_rd;
    @(posedge clk);
    for (int t = 0; t < F; t++) begin
      @(negedge clk);
      if (t == 0) begin rd_i = 1'b0; wr_i = 1'b0; end
      c = exp_ctl(op, t);
      chk(op == 1 ? "R5" : op == 2 ? "R6" : "R8", {tag, " ctl"},
          256'({pre_o, |wl_o, sae_o, wdrv_o}), 256'(c));
      chk("R2", {tag, " blk"}, 256'(blk_en_o),
          op != 0 ? 256'(32'(1) << a[14:10]) : '0);
      chk("R3", {tag, " pre"}, 256'(row_pre_o),
          op != 0 ? 256'(64'(1) << a[7:2]) : '0);
      chk("R3", {tag, " wl"}, wl_o, c[2] ? (256'(1) << a[9:2]) : '0);
      chk("R3", {tag, " grp"}, 256'(wl_grp_o),
          c[2] ? 256'(4'(1) << a[9:8]) : '0);
      chk("R4", {tag, " col"}, 256'(col_sel_o),
          op != 0 ? 256'(4'(1) << a[1:0]) : '0);
      chk("R9", {tag, " err"}, 256'(err_o), 256'(rd && wr));
      chk("R11", {tag, " cyc"}, 256'(cyc_o), 256'(t == F-1));
      chk(op == 1 ? "R7" : "R8", {tag, " rdata"}, 256'(rdata_o),
          256'((op == 1 && t >= P+W+S) ? nrd : last_rd));
    end
    if (op == 1) last_rd = nrd;
    if (op == 2) begin mdl[idx] = d; vld[idx] = 1'b1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < (1<<MAW); i++) begin vld[i] = 1'b0; mdl[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", "reset strobes", 256'({pre_o, wdrv_o, sae_o, err_o, cyc_o}), '0);
    chk("R1", "reset selects", 256'(blk_en_o) | wl_o | 256'(col_sel_o), '0);
    chk("R1", "reset rdata", 256'(rdata_o), '0);
    rst_ni = 1'b1;
    run_frame(1'b0, 1'b0, '0, '0, "R1 first");

    // directed
    run_frame(1'b0, 1'b1, 15'h7fff, 32'hdead_beef, "wr max");
    run_frame(1'b1, 1'b0, 15'h7fff, '0, "R10 raw");
    run_frame(1'b0, 1'b1, 15'h0000, 32'h1234_5678, "wr zero");
    run_frame(1'b1, 1'b0, 15'h0000, '0, "R10 raw0");
    run_frame(1'b0, 1'b0, 15'h1555, 32'hffff_ffff, "R8 idle");
    run_frame(1'b1, 1'b1, 15'h0000, 32'hcafe_f00d, "R9 both");
    run_frame(1'b1, 1'b0, 15'h0000, '0, "R9 after");
    // R12: differs only in block bits, same stored word
    run_frame(1'b0, 1'b1, 15'h0123, 32'ha5a5_5a5a, "R12 wr");
    run_frame(1'b1, 1'b0, 15'h4123, '0, "R12 alias");
    // R11: stray pulse between sampling edges
    while (cyc_o) @(negedge clk);
    rd_i = 1'b1; wr_i = 1'b1; addr_i = 15'h0123;
    @(negedge clk);
    rd_i = 1'b0; wr_i = 1'b0;
    run_frame(1'b0, 1'b0, 15'h0123, '0, "R11 stray");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      int k;
      a = AW'($urandom);
      d = $urandom;
      k = int'($urandom_range(0, 9));
      if (k < 4) run_frame(1'b0, 1'b1, a, d, "rnd wr");
      else if (k < 8) begin
        if (vld[int'(a[MAW-1:0])]) run_frame(1'b1, 1'b0, a, d, "rnd rd");
        else run_frame(1'b0, 1'b1, a, d, "rnd wr");
      end
      else if (k == 8) run_frame(1'b0, 1'b0, a, d, "rnd idle");
      else run_frame(1'b1, 1'b1, a, d, "rnd both");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule